// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches every input pin of a wide general-purpose I/O port and turns pin activity into interrupt requests. Each pin is first brought into the clock domain through a two-stage synchronizer. It can then be armed for a rising edge, a falling edge, or both. It can also be switched to level detection with a chosen active polarity. Any detected event sets a sticky status bit for that pin. The unmasked status bits of all pins are ORed into one interrupt line.

Per-pin settings are held in 32-bit banks, one word per bank for each kind of setting. Software reaches them through a plain word-addressed read/write port. The word address has two fields: the register kind sits in the upper bits, and the bank index (pin number divided by 32) sits in the low bits. Neighbouring banks of the same kind therefore lie at consecutive word addresses. With the default 93 pins the last bank carries only 29 pins. Its missing bits read as zero and ignore writes.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the rise-disable, fall-disable, level-gate and interrupt-mask words hold 1 in every implemented bit. The level-select, level-invert and status words read 0, and `irq_o` is low.
- R2: With its level-select bit 0 and its rise-disable bit 0, a pin that goes from 0 to 1 sets its status bit. The status bit reads 1 three clock edges after the pin changes.
- R3: With its level-select bit 0 and its fall-disable bit 0, a pin that goes from 1 to 0 sets its status bit, with the same latency as R2.
- R4: A pin transition in the direction whose disable bit is 1 leaves the status bit unchanged.
- R5: With level-select 1, level-gate 0 and level-invert 0, the status bit is set on every cycle the synchronized pin is high. A write-one-to-clear while the pin stays high leaves it reading 1. Once the pin is low, a clear sticks.
- R6: With level-invert 1, level detection fires while the pin is low instead of high.
- R7: A level-gate bit of 1 suppresses level detection for that pin even when its level-select bit is 1.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. No status bit falls without such a write.
- R9: `irq_o` is high exactly when some pin has its status bit 1 and its interrupt-mask bit 0. A masked pin's status does not raise `irq_o`.
- R10: The word address is {kind, bank}: the kind is in the upper 3 bits and the bank index in the low 2 bits. The kind codes are 0 rise-disable, 1 fall-disable, 2 level-select, 3 level-invert, 4 level-gate, 5 interrupt-mask and 6 status. Pin n maps to bank n/32, bit n%32, and events on one bank do not appear in another.
- R11: In the last bank only bits 0 to 28 exist. They work like any other pin (pin 92 is bank 2, bit 28). Bits 29 to 31 read 0 and ignore writes.
- R12: With level-select 1, edge detection is off: a rising edge on an edge-enabled pin whose level detection is gated sets no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 93 | Raw pin levels, may be asynchronous |
| reg_addr | input | 5 | Word address {kind, bank} |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take it as given that status bits fall only through a write of ones to a status word. They also assume the register port addresses at most one word per cycle, so a clear can be tied to the write strobe of that same cycle. The bench drives pins and the register port only on falling clock edges and holds each write for exactly one rising edge. It never writes a status word while it is checking that a bit stays set. Because of this, every drop or rise of a status bit the checker sees can be traced to a specific stimulus cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int KIND_W = 3;

   // Register kinds, upper field of the word address
   typedef enum logic [KIND_W-1:0] {
      K_RISE_OFF  = 3'd0,
      K_FALL_OFF  = 3'd1,
      K_LVL_SEL   = 3'd2,
      K_LVL_INV   = 3'd3,
      K_LVL_GATE  = 3'd4,
      K_IRQ_MASK  = 3'd5,
      K_STATUS    = 3'd6
   } reg_kind_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 93,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_irq_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[s] <= '0;
            else if (s == 0)
               chain[s] <= d_i;
            else
               chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int                BANK_W = 32,
   parameter logic [BANK_W-1:0] VALID  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] pin_s,
   input  logic              wr_en,
   input  logic [KIND_W-1:0] wr_kind,
   input  logic [BANK_W-1:0] wr_data,
   input  logic [KIND_W-1:0] rd_kind,
   output logic [BANK_W-1:0] rd_data,
   output logic [BANK_W-1:0] status_o,
   output logic [BANK_W-1:0] mask_o
);
   logic [BANK_W-1:0] rise_off, fall_off, lvl_sel, lvl_inv, lvl_gate, irq_mask;
   logic [BANK_W-1:0] status_q, prev_q;
   logic [BANK_W-1:0] rise_ev, fall_ev, lvl_ev, evt, clr;
   logic [BANK_W-1:0] wval;

   assign wval = wr_data & VALID;

   // configuration words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_off <= VALID;
         fall_off <= VALID;
         lvl_sel  <= '0;
         lvl_inv  <= '0;
         lvl_gate <= VALID;
         irq_mask <= VALID;
      end else if (wr_en) begin
         case (wr_kind)
            K_RISE_OFF: rise_off <= wval;
            K_FALL_OFF: fall_off <= wval;
            K_LVL_SEL:  lvl_sel  <= wval;
            K_LVL_INV:  lvl_inv  <= wval;
            K_LVL_GATE: lvl_gate <= wval;
            K_IRQ_MASK: irq_mask <= wval;
            default: ;
         endcase
      end
   end

   // event detection on synchronized pins
   always_comb begin
      rise_ev = ~lvl_sel & ~rise_off & pin_s & ~prev_q;
      fall_ev = ~lvl_sel & ~fall_off & ~pin_s & prev_q;
      lvl_ev  = lvl_sel & ~lvl_gate & (pin_s ^ lvl_inv);
      evt     = (rise_ev | fall_ev | lvl_ev) & VALID;
      clr     = (wr_en && wr_kind == K_STATUS) ? wval : '0;
   end

   // sticky status, a fresh event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         prev_q   <= '0;
      end else begin
         status_q <= (status_q & ~clr) | evt;
         prev_q   <= pin_s & VALID;
      end
   end

   always_comb begin
      case (rd_kind)
         K_RISE_OFF: rd_data = rise_off;
         K_FALL_OFF: rd_data = fall_off;
         K_LVL_SEL:  rd_data = lvl_sel;
         K_LVL_INV:  rd_data = lvl_inv;
         K_LVL_GATE: rd_data = lvl_gate;
         K_IRQ_MASK: rd_data = irq_mask;
         K_STATUS:   rd_data = status_q;
         default:    rd_data = '0;
      endcase
   end

   assign status_o = status_q;
   assign mask_o   = irq_mask;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 93,
   parameter int BANK_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W,
   localparam int BSEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W     = KIND_W + BSEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [BANK_W-1:0]   reg_wdata,
   output logic [BANK_W-1:0]   reg_rdata,
   output logic                irq_o
);
   localparam int PAD_W = NUM_BANKS * BANK_W;

   logic [NUM_PINS-1:0] pin_s;
   logic [PAD_W-1:0]    pin_pad, status_pad, mask_pad;
   logic [BANK_W-1:0]   bank_rd [NUM_BANKS];
   logic [KIND_W-1:0]   kind;
   logic [BSEL_W-1:0]   bsel;
   logic [NUM_PINS-1:0] status_all, mask_all;

   assign kind = reg_addr[ADDR_W-1:BSEL_W];
   assign bsel = reg_addr[BSEL_W-1:0];

   generate
      if (NUM_PINS < 1 || BANK_W < 1) begin : g_bad_cfg
         $error("gpio_irq_ctrl: NUM_PINS and BANK_W must be positive");
      end
      if (PAD_W > NUM_PINS) begin : g_pad
         assign pin_pad = {{(PAD_W-NUM_PINS){1'b0}}, pin_s};
      end else begin : g_nopad
         assign pin_pad = pin_s;
      end
   endgenerate

   gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pin_i),
      .q_o  (pin_s)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int LEFT = NUM_PINS - b*BANK_W;
         localparam int HI   = (LEFT >= BANK_W) ? BANK_W : LEFT;
         localparam logic [BANK_W-1:0] VM = {BANK_W{1'b1}} >> (BANK_W - HI);

         gpio_irq_bank #(.BANK_W(BANK_W), .VALID(VM)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pin_pad[b*BANK_W +: BANK_W]),
            .wr_en   (reg_we && (bsel == BSEL_W'(b))),
            .wr_kind (kind),
            .wr_data (reg_wdata),
            .rd_kind (kind),
            .rd_data (bank_rd[b]),
            .status_o(status_pad[b*BANK_W +: BANK_W]),
            .mask_o  (mask_pad[b*BANK_W +: BANK_W])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (bsel == BSEL_W'(b)) reg_rdata = bank_rd[b];
   end

   assign status_all = status_pad[NUM_PINS-1:0];
   assign mask_all   = mask_pad[NUM_PINS-1:0];
   assign irq_o      = |(status_pad & ~mask_pad);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS  = 93,
   parameter int BANK_W    = 32,
   parameter int NUM_BANKS = 3,
   parameter int BSEL_W    = 2,
   parameter int ADDR_W    = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_we,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [BANK_W-1:0]   reg_rdata,
   input logic                irq_o,
   input logic [NUM_PINS-1:0] status_all,
   input logic [NUM_PINS-1:0] mask_all
);
   localparam int LAST_HI = NUM_PINS - (NUM_BANKS-1)*BANK_W;

   logic st_wr;
   assign st_wr = reg_we && (reg_addr[ADDR_W-1:BSEL_W] == K_STATUS);

   // R8: without a status write, no status bit may fall
   assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr |=> ((~status_all & $past(status_all)) == '0));

   // R9: fully masked port never requests
   assert_all_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_all) |-> !irq_o);

   // R9: a request needs some pending status
   assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|status_all));

   generate
      if (LAST_HI < BANK_W) begin : g_short
         // R11: absent bits of the last bank read zero
         assert_short_bank_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr[BSEL_W-1:0] == BSEL_W'(NUM_BANKS-1)) |-> (reg_rdata[BANK_W-1:LAST_HI] == '0));
      end
   endgenerate
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .BANK_W   (BANK_W),
   .NUM_BANKS(NUM_BANKS),
   .BSEL_W   (BSEL_W),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .irq_o     (irq_o),
   .status_all(status_all),
   .mask_all  (mask_all)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
   localparam logic [2:0] RISE = 3'd0, FALL = 3'd1, SEL = 3'd2, INV = 3'd3,
                          GATE = 3'd4, IMSK = 3'd5, STAT = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [92:0] pins = '0;
   logic [4:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_addr(addr),
      .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] k, input int b, input logic [31:0] d);
      @(negedge clk);
      addr = {k, 2'(b)}; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] k, input int b, output logic [31:0] d);
      addr = {k, 2'(b)};
      #1 d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(RISE, 0, v); check("R1 rise-disable bank0", v, 32'hFFFF_FFFF);
      rd(FALL, 1, v); check("R1 fall-disable bank1", v, 32'hFFFF_FFFF);
      rd(GATE, 0, v); check("R1 level-gate bank0", v, 32'hFFFF_FFFF);
      rd(IMSK, 2, v); check("R1/R11 mask bank2", v, 32'h1FFF_FFFF);
      rd(SEL, 0, v);  check("R1 level-select bank0", v, 32'h0);
      rd(INV, 1, v);  check("R1 level-invert bank1", v, 32'h0);
      for (int b = 0; b < 3; b++) begin
         rd(STAT, b, v); check("R1 status clear", v, 32'h0);
      end
      check("R1 irq low", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_rise_edge();
      logic [31:0] v;
      wr(RISE, 0, ~(32'h1 << 5));
      wr(IMSK, 0, ~(32'h1 << 5));
      pins[5] = 1'b1;
      idle(3);
      rd(STAT, 0, v); check("R2 rising edge pin5", v, 32'h20);
      check("R9 irq unmasked", {31'h0, irq}, 32'h1);
      wr(STAT, 0, 32'h0);
      rd(STAT, 0, v); check("R8 write zero keeps", v, 32'h20);
      wr(STAT, 0, 32'h20);
      rd(STAT, 0, v); check("R8 write one clears", v, 32'h0);
      check("R9 irq drops", {31'h0, irq}, 32'h0);
      pins[5] = 1'b0;
      idle(5);
      rd(STAT, 0, v); check("R4 falling disabled", v, 32'h0);
   endtask

   task automatic t_fall_edge();
      logic [31:0] v;
      wr(FALL, 1, ~(32'h1 << 8));
      pins[40] = 1'b1;
      idle(5);
      rd(STAT, 1, v); check("R4 rising disabled pin40", v, 32'h0);
      pins[40] = 1'b0;
      idle(3);
      rd(STAT, 1, v); check("R3/R10 falling edge pin40 bank1 bit8", v, 32'h100);
      rd(STAT, 0, v); check("R10 no cross-bank", v, 32'h0);
      check("R9 masked status no irq", {31'h0, irq}, 32'h0);
      wr(STAT, 1, 32'h100);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(SEL, 2, 32'h40);
      wr(GATE, 2, ~32'h40);
      pins[70] = 1'b1;
      idle(3);
      rd(STAT, 2, v); check("R5 high level sets", v, 32'h40);
      wr(STAT, 2, 32'h40);
      rd(STAT, 2, v); check("R5 clear does not hold", v, 32'h40);
      pins[70] = 1'b0;
      idle(3);
      wr(STAT, 2, 32'h40);
      idle(3);
      rd(STAT, 2, v); check("R5 clear sticks when low", v, 32'h0);
      wr(INV, 2, 32'h40);
      idle(2);
      rd(STAT, 2, v); check("R6 active-low level", v, 32'h40);
      wr(GATE, 2, 32'hFFFF_FFFF);
      wr(STAT, 2, 32'h40);
      idle(3);
      rd(STAT, 2, v); check("R7 gate suppresses level", v, 32'h0);
   endtask

   task automatic t_mode_edge();
      logic [31:0] v;
      wr(RISE, 2, ~(32'h1 << 7));
      wr(SEL, 2, 32'hC0);
      pins[71] = 1'b1;
      idle(5);
      rd(STAT, 2, v); check("R12 level mode blocks edge", v, 32'h0);
   endtask

   task automatic t_top_pin();
      logic [31:0] v;
      wr(RISE, 2, ~(32'h1 << 28));
      pins[92] = 1'b1;
      idle(3);
      rd(STAT, 2, v); check("R11 pin92 bank2 bit28", v, 32'h1000_0000);
      wr(RISE, 2, 32'hFFFF_FFFF);
      rd(RISE, 2, v); check("R11 upper bits ignored", v, 32'h1FFF_FFFF);
      wr(IMSK, 2, ~(32'h1 << 28));
      check("R9 irq from pin92", {31'h0, irq}, 32'h1);
      wr(IMSK, 2, 32'hFFFF_FFFF);
      check("R9 mask hides pin92", {31'h0, irq}, 32'h0);
      rd(STAT, 2, v); check("R9 status kept under mask", v, 32'h1000_0000);
      wr(STAT, 2, 32'hFFFF_FFFF);
      rd(STAT, 2, v); check("R8 full clear", v, 32'h0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_rise_edge();
      t_fall_edge();
      t_level();
      t_mode_edge();
      t_top_pin();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule